// File: doc/BRIEF.md
# I2C Streaming Slave Transmit Port

This block lets an external I2C bus master pull a continuous byte stream out of a chip without any register map. An on-chip producer writes bytes into an internal queue. The master addresses the port for reading and receives those bytes in the order they were written. When the queue has nothing left, every requested byte reads as the filler value 0xFF. The port is always a slave. It never starts a transfer, and the master alone drives SCL and sets the bit rate.

A level output tells the master that the queue holds data, so the master can use it to trigger a poll instead of polling blind. If the port is left unread for a long time, it assumes nobody is listening. It then empties the queue and refuses new bytes until the next read addressing. A configuration input switches this idle flush off.

Bytes that would push the queue past its capacity are dropped, and a sticky flag records the loss. Bytes that the master writes to the port appear one at a time on a received-byte output. Bus lines are sampled through synchronizers on the system clock. SDA is only ever pulled low or released.

Top module: `i2c_stream_slave`

## Requirements
- R1: With the address override off, the port acknowledges the 7-bit address 0x42 (header byte = address in bits 7..1, R/W in bit 0, 1 = read) and leaves any other address unacknowledged.
- R2: With `cfg_addr_override` high, the port answers to `cfg_addr` and no longer to 0x42.
- R3: A master read returns queued bytes in enqueue order, MSB first, and removes each byte it sends from the queue.
- R4: A read from an empty queue returns 0xFF for every byte and leaves the queue unchanged.
- R5: `data_ready` is high exactly when the queue holds at least one byte.
- R6: Each byte the master writes is acknowledged and is presented on `rx_data` with a one-cycle `rx_valid` pulse. Written bytes do not enter the outbound queue.
- R7: With `cfg_timeout_en` high, `IDLE_CYCLES` system cycles without a read addressing empty the queue. Enqueue requests are then refused until the next read addressing.
- R8: With `cfg_timeout_en` low, queued bytes are kept for any length of time without reads.
- R9: The queue holds `DEPTH` bytes. An enqueue into a full queue is dropped and sets `overflow`, which stays high until reset.
- R10: A byte that the master NACKs is consumed. The next read starts with the following byte.
- R11: SDA is only pulled low or released, and it is released after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_drive_low | output | 1 | High pulls SDA low; low releases it |
| wr_valid | input | 1 | Producer enqueue request |
| wr_data | input | 8 | Byte to enqueue |
| data_ready | output | 1 | Queue is not empty |
| overflow | output | 1 | Sticky: a byte was dropped on a full queue |
| rx_valid | output | 1 | One-cycle strobe for a byte written by the master |
| rx_data | output | 8 | Byte written by the master |
| cfg_addr_override | input | 1 | Use `cfg_addr` instead of 0x42 |
| cfg_addr | input | 7 | Runtime slave address |
| cfg_timeout_en | input | 1 | Enable the idle flush |

## Verification
An accepted enqueue changes `data_ready` at the next clock edge, so the bench reads that flag at the falling edge after each enqueue. Every change the port makes on SDA comes three system cycles after SCL falls: two cycles for the synchronizer and one for the state register. The bench master therefore holds SCL low for sixteen cycles and samples SDA halfway through SCL high, well clear of both transitions. `rx_valid` arrives on the same three-cycle delay after the eighth falling SCL edge. A monitor logs it on falling clock edges, and the log is compared after the STOP. The idle flush takes effect one cycle after the terminal count, so the bench waits twenty cycles past `IDLE_CYCLES` before it checks the flag.

// File: rtl/i2c_stream_pkg.sv
package i2c_stream_pkg;

    localparam logic [6:0] DEFAULT_SLAVE_ADDR = 7'h42;
    localparam logic [7:0] FILL_BYTE          = 8'hFF;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_ADDR_ACK,
        LS_READ,
        LS_RD_ACK,
        LS_WRITE,
        LS_WR_ACK
    } link_state_t;

    function automatic logic header_hits(input logic [7:0] hdr, input logic [6:0] addr);
        return hdr[7:1] == addr;
    endfunction

endpackage

// File: rtl/i2c_stream_sync.sv
module i2c_stream_sync
    import i2c_stream_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic scl_meta, scl_s, scl_q;
    logic sda_meta, sda_s, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_meta <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
            sda_meta <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
        end else begin
            scl_meta <= scl_in; scl_s <= scl_meta; scl_q <= scl_s;
            sda_meta <= sda_in; sda_s <= sda_meta; sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/i2c_stream_fifo.sv
module i2c_stream_fifo #(
    parameter int DEPTH = 4096,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH):0] count,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = count == (AW+1)'(DEPTH);
    assign empty   = count == '0;
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2c_stream_idle.sv
module i2c_stream_idle #(
    parameter int IDLE_CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic rd_hit,
    output logic flush,
    output logic locked
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign flush = enable & ~rd_hit & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else begin
            if (!enable || rd_hit || flush) cnt <= '0;
            else                            cnt <= cnt + 1'b1;
            if (rd_hit)     locked <= 1'b0;
            else if (flush) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_stream_link.sv
module i2c_stream_link
    import i2c_stream_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [6:0] own_addr,
    input  logic [7:0] tx_byte,
    input  logic       tx_avail,
    output logic       pop,
    output logic       rd_hit,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       sda_low
);
    link_state_t state;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg;
    logic        rw, nack;
    logic [7:0]  next_byte;
    logic        load_now;

    assign next_byte = tx_avail ? tx_byte : FILL_BYTE;

    always_comb begin
        load_now = 1'b0;
        if (!evt.start && !evt.stop && evt.scl_fall) begin
            if (state == LS_ADDR_ACK && rw)   load_now = 1'b1;
            if (state == LS_RD_ACK && !nack)  load_now = 1'b1;
        end
        pop = load_now & tx_avail;
    end

    always_ff @(posedge clk) begin
        rx_valid <= 1'b0;
        rd_hit   <= 1'b0;
        if (rst) begin
            state   <= LS_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            sda_low <= 1'b0;
            rx_data <= '0;
        end else if (evt.start) begin
            state   <= LS_ADDR;
            bit_cnt <= '0;
            sda_low <= 1'b0;
        end else if (evt.stop) begin
            state   <= LS_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (state)
                LS_ADDR, LS_WRITE: begin
                    if (evt.scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], evt.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (evt.scl_fall && bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        if (state == LS_WRITE) begin
                            rx_data  <= shreg;
                            rx_valid <= 1'b1;
                            sda_low  <= 1'b1;
                            state    <= LS_WR_ACK;
                        end else if (header_hits(shreg, own_addr)) begin
                            sda_low <= 1'b1;
                            rw      <= shreg[0];
                            rd_hit  <= shreg[0];
                            state   <= LS_ADDR_ACK;
                        end else begin
                            state <= LS_IDLE;
                        end
                    end
                end
                LS_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        bit_cnt <= '0;
                        if (rw) begin
                            shreg   <= next_byte;
                            sda_low <= ~next_byte[7];
                            state   <= LS_READ;
                        end else begin
                            sda_low <= 1'b0;
                            state   <= LS_WRITE;
                        end
                    end
                end
                LS_READ: begin
                    if (evt.scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            sda_low <= 1'b0;
                            state   <= LS_RD_ACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_low <= ~shreg[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                LS_RD_ACK: begin
                    if (evt.scl_rise) begin
                        nack <= evt.sda;
                    end else if (evt.scl_fall) begin
                        if (nack) begin
                            state <= LS_IDLE;
                        end else begin
                            shreg   <= next_byte;
                            sda_low <= ~next_byte[7];
                            bit_cnt <= '0;
                            state   <= LS_READ;
                        end
                    end
                end
                LS_WR_ACK: begin
                    if (evt.scl_fall) begin
                        sda_low <= 1'b0;
                        bit_cnt <= '0;
                        state   <= LS_WRITE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_stream_slave.sv
module i2c_stream_slave
    import i2c_stream_pkg::*;
#(
    parameter int DEPTH       = 4096,
    parameter int IDLE_CYCLES = 100_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_drive_low,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       data_ready,
    output logic       overflow,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    input  logic       cfg_addr_override,
    input  logic [6:0] cfg_addr,
    input  logic       cfg_timeout_en
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    bus_evt_t         evt;
    logic [6:0]       own_addr;
    logic             q_push, q_pop, q_flush, q_full, q_empty;
    logic [7:0]       q_head;
    logic [CNT_W-1:0] q_count;
    logic             rd_hit, idle_locked;

    assign own_addr   = cfg_addr_override ? cfg_addr : DEFAULT_SLAVE_ADDR;
    assign q_push     = wr_valid & ~idle_locked & ~q_full;
    assign data_ready = ~q_empty;

    always_ff @(posedge clk) begin
        if (rst)                                     overflow <= 1'b0;
        else if (wr_valid && !idle_locked && q_full) overflow <= 1'b1;
    end

    i2c_stream_sync u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .evt(evt)
    );

    i2c_stream_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk(clk), .rst(rst), .push(q_push), .push_data(wr_data),
        .pop(q_pop), .flush(q_flush), .head(q_head), .count(q_count),
        .full(q_full), .empty(q_empty)
    );

    i2c_stream_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk(clk), .rst(rst), .enable(cfg_timeout_en), .rd_hit(rd_hit),
        .flush(q_flush), .locked(idle_locked)
    );

    i2c_stream_link u_link (
        .clk(clk), .rst(rst), .evt(evt), .own_addr(own_addr),
        .tx_byte(q_head), .tx_avail(~q_empty), .pop(q_pop), .rd_hit(rd_hit),
        .rx_valid(rx_valid), .rx_data(rx_data), .sda_low(sda_drive_low)
    );
endmodule

// File: rtl/i2c_stream_checker.sv
module i2c_stream_checker #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             q_push,
    input logic             q_pop,
    input logic             q_flush,
    input logic [CNT_W-1:0] q_count,
    input logic             data_ready,
    input logic             overflow,
    input logic             idle_locked,
    input logic             stop_seen,
    input logic             sda_drive_low
);
    assert_pop_consumes_R3: assert property (@(posedge clk) disable iff (rst)
        (q_pop && !q_push && !q_flush) |=> (q_count == $past(q_count) - 1'b1));

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
        q_flush |=> !data_ready);

    assert_locked_empty_R7: assert property (@(posedge clk) disable iff (rst)
        idle_locked |-> !data_ready);

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_stop_releases_R11: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_drive_low);
endmodule

bind i2c_stream_slave i2c_stream_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .q_push(q_push), .q_pop(q_pop), .q_flush(q_flush),
    .q_count(q_count), .data_ready(data_ready), .overflow(overflow),
    .idle_locked(idle_locked), .stop_seen(evt.stop), .sda_drive_low(sda_drive_low)
);

// File: tb/sim_i2c_stream_slave.sv
module sim_i2c_stream_slave;
    localparam int DEPTH = 16;
    localparam int IDLE  = 2000;
    localparam int HALF  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       sda_drive_low;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       data_ready, overflow, rx_valid;
    logic [7:0] rx_data;
    logic       cfg_addr_override = 1'b0;
    logic [6:0] cfg_addr = 7'h00;
    logic       cfg_timeout_en = 1'b0;
    logic       scl_line, sda_line;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;
    logic [7:0] mq[$];
    logic [7:0] rx_log[$];
    bit model_locked = 1'b0;

    always #2 clk = ~clk;

    assign scl_line = ~m_scl_low;
    assign sda_line = ~(m_sda_low | sda_drive_low);

    i2c_stream_slave #(.DEPTH(DEPTH), .IDLE_CYCLES(IDLE)) u0 (
        .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
        .sda_drive_low(sda_drive_low), .wr_valid(wr_valid), .wr_data(wr_data),
        .data_ready(data_ready), .overflow(overflow), .rx_valid(rx_valid),
        .rx_data(rx_data), .cfg_addr_override(cfg_addr_override),
        .cfg_addr(cfg_addr), .cfg_timeout_en(cfg_timeout_en)
    );

    always @(negedge clk) if (!rst && rx_valid) rx_log.push_back(rx_data);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_pop();
        if (mq.size() > 0) return mq.pop_front();
        return 8'hFF;
    endfunction

    function automatic void model_push(input logic [7:0] b);
        if (model_locked) return;
        if (mq.size() < DEPTH) mq.push_back(b);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enqueue(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        model_push(b);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wait_cyc(HALF);
        m_scl_low = 1'b0; wait_cyc(HALF);
        m_sda_low = 1'b1; wait_cyc(HALF);
        m_scl_low = 1'b1; wait_cyc(2);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wait_cyc(HALF);
        m_scl_low = 1'b0; wait_cyc(HALF);
        m_sda_low = 1'b0; wait_cyc(HALF);
    endtask

    task automatic clock_bit(input bit pull_low, output bit sampled);
        m_sda_low = pull_low; wait_cyc(HALF);
        m_scl_low = 1'b0;     wait_cyc(HALF / 2);
        sampled = sda_line;   wait_cyc(HALF / 2);
        m_scl_low = 1'b1;     wait_cyc(2);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(~b[i], s);
        clock_bit(1'b0, s);
        ack = ~s;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b0, s);
            b[i] = s;
        end
        clock_bit(give_ack, s);
    endtask

    task automatic rd_txn(input logic [6:0] addr, input int n, input bit exp_ack, input string req);
        bit ack;
        logic [7:0] got, exp;
        string tag;
        bus_start();
        write_byte({addr, 1'b1}, ack);
        check(ack == exp_ack, req, ack, exp_ack);
        if (ack) begin
            model_locked = 1'b0;
            for (int i = 0; i < n; i++) begin
                read_byte(i != n - 1, got);
                tag = (mq.size() > 0) ? "R3" : "R4";
                exp = model_pop();
                check(got == exp, tag, got, exp);
            end
        end
        bus_stop();
        wait_cyc(4);
        check(sda_drive_low == 1'b0, "R11", sda_drive_low, 0);
    endtask

    task automatic wr_txn(input logic [6:0] addr, input int n);
        bit ack;
        logic [7:0] sent[$];
        logic [7:0] b;
        rx_log.delete();
        bus_start();
        write_byte({addr, 1'b0}, ack);
        check(ack, "R6", ack, 1);
        for (int i = 0; i < n; i++) begin
            b = 8'($urandom_range(0, 255));
            sent.push_back(b);
            write_byte(b, ack);
            check(ack, "R6", ack, 1);
        end
        bus_stop();
        wait_cyc(4);
        check(rx_log.size() == n, "R6", rx_log.size(), n);
        for (int i = 0; i < n && i < rx_log.size(); i++)
            check(rx_log[i] == sent[i], "R6", rx_log[i], sent[i]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        bit ack;
        void'($urandom(32'd1234));
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);

        // Reset state
        check(data_ready == 1'b0, "R5", data_ready, 0);
        check(overflow == 1'b0, "R9", overflow, 0);
        check(sda_drive_low == 1'b0, "R11", sda_drive_low, 0);

        // R4: empty reads give filler, R1: default address
        rd_txn(7'h42, 3, 1'b1, "R1");
        check(data_ready == 1'b0, "R4", data_ready, 0);
        rd_txn(7'h43, 1, 1'b0, "R1");

        // R6: master writes do not touch the queue
        wr_txn(7'h42, 3);
        check(data_ready == 1'b0, "R6", data_ready, 0);

        // Random enqueue / read mix
        for (int it = 0; it < 8; it++) begin
            automatic int n = $urandom_range(0, 5);
            automatic int m = $urandom_range(1, 6);
            for (int k = 0; k < n; k++) enqueue(8'($urandom_range(0, 255)));
            check(data_ready == (mq.size() != 0), "R5", data_ready, mq.size() != 0);
            rd_txn(7'h42, m, 1'b1, "R1");
            check(data_ready == (mq.size() != 0), "R5", data_ready, mq.size() != 0);
        end
        if (mq.size() > 0) rd_txn(7'h42, mq.size(), 1'b1, "R3");

        // R10: NACKed byte is consumed
        enqueue(8'h3C);
        enqueue(8'hC3);
        rd_txn(7'h42, 1, 1'b1, "R10");
        rd_txn(7'h42, 1, 1'b1, "R10");
        check(data_ready == 1'b0, "R10", data_ready, 0);

        // R2: address override
        cfg_addr_override = 1'b1;
        cfg_addr = 7'h21;
        enqueue(8'h99);
        rd_txn(7'h42, 1, 1'b0, "R2");
        check(data_ready == 1'b1, "R2", data_ready, 1);
        rd_txn(7'h21, 1, 1'b1, "R2");
        cfg_addr_override = 1'b0;

        // R9: overflow
        for (int k = 0; k < DEPTH + 3; k++) enqueue(8'(k * 7 + 1));
        check(overflow == 1'b1, "R9", overflow, 1);
        check(data_ready == 1'b1, "R9", data_ready, 1);
        rd_txn(7'h42, DEPTH + 1, 1'b1, "R9");
        check(overflow == 1'b1, "R9", overflow, 1);

        // R7: idle flush and lock
        @(negedge clk);
        cfg_timeout_en = 1'b1;
        enqueue(8'h11);
        enqueue(8'h22);
        enqueue(8'h33);
        check(data_ready == 1'b1, "R7", data_ready, 1);
        wait_cyc(IDLE + 20);
        mq.delete();
        model_locked = 1'b1;
        check(data_ready == 1'b0, "R7", data_ready, 0);
        enqueue(8'h5A);
        check(data_ready == 1'b0, "R7", data_ready, 0);
        rd_txn(7'h42, 1, 1'b1, "R7");
        enqueue(8'h77);
        check(data_ready == 1'b1, "R7", data_ready, 1);
        cfg_timeout_en = 1'b0;

        // R8: no flush when disabled
        wait_cyc(3 * IDLE);
        check(data_ready == 1'b1, "R8", data_ready, 1);
        rd_txn(7'h42, 1, 1'b1, "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule